// File: doc/BRIEF.md
# Configurable Parallel Host Port

This block links an external host bus to an internal processor core through two 16-bit data registers. The host fills the inbound register, which the core reads, and drains the outbound register, which the core writes. On the core side both registers sit behind one address: a core read returns the inbound register and a core write loads the outbound register. Two handshake flags tell the host when the inbound register holds unread data and when the outbound register has been drained.

A 16-bit control register configures the host side. It selects the host bus style: either two separate active-low strobes (one for host writes, one for host reads) or a direction line plus one data strobe of programmable polarity. It also selects 8-bit or 16-bit host transfers, which level of the byte-select pin picks the low byte, the flag pin polarity, whether the two flags are merged onto the full pin, and the sense of the empty bit in the status word. A status-select pin lets the host read a status word in place of data.

Host pins are taken to be already synchronous to `clk`. A host write is recognised in the first cycle its strobe is seen active. A host read is completed in the first cycle its strobe is seen inactive again. The asynchronous reset is released through a two-stage synchroniser.

Top module: `par_host_port`

## Requirements
- R1: After reset the control register reads 0, the inbound register reads 0, the full pin is 0 and the empty pin is 1.
- R2: Control bits 6..0 are writable and read back as written. Bits 15..7 always read 0. The bits are: 0 width (1 = 16-bit), 1 bus style (1 = direction line plus data strobe), 2 data-strobe active level, 3 byte-select level that picks the low byte, 4 flag pin inversion, 5 flag merge, 6 status empty-bit inversion.
- R3: With bus style 0, `h_line_a` low is a host write strobe and `h_line_b` low is a host read strobe.
- R4: With bus style 1, `h_line_a` is the direction (1 = read, 0 = write) and `h_line_b` is the data strobe, active when it equals control bit 2.
- R5: In 16-bit mode a host write loads all of `h_din` into the inbound register, and a host data read returns the whole outbound register.
- R6: In 8-bit mode the byte moves on bits 7..0 of `h_din` and `h_dout`, with bits 15..8 of `h_dout` zero. The low byte is selected when `h_bsel` equals control bit 3, and the high byte otherwise. Only a high-byte access completes a transfer.
- R7: The full flag is set one cycle after a completing host write and cleared one cycle after a core read. If both happen in the same cycle, the set wins.
- R8: The empty flag is cleared one cycle after a core write and set when a completing host data read ends. If both happen in the same cycle, the clear wins.
- R9: A host read with `h_stat` high returns the status word: bit 0 = full, bit 1 = empty XOR control bit 6, all other bits 0. Such a read does not complete a transfer.
- R10: With control bit 4 set, both flag pins are inverted.
- R11: With control bit 5 set, the full pin carries full OR empty. The empty pin is unchanged.
- R12: In the cycle after a control write, no host transfer is recognised, so a level that becomes active only because of the new configuration starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_rd | input | 1 | Core reads the inbound register |
| core_rdata | output | 16 | Inbound register contents |
| core_wr | input | 1 | Core writes the outbound register |
| core_wdata | input | 16 | Data for the outbound register |
| ctl_wr | input | 1 | Control register write |
| ctl_wdata | input | 16 | Control register write data |
| ctl_rdata | output | 16 | Control register read value |
| h_line_a | input | 1 | Host write strobe, or direction line |
| h_line_b | input | 1 | Host read strobe, or data strobe |
| h_bsel | input | 1 | Host byte select |
| h_stat | input | 1 | Host status select on reads |
| h_din | input | 16 | Host write data |
| h_dout | output | 16 | Host read data |
| flag_full | output | 1 | Inbound-full flag pin |
| flag_empty | output | 1 | Outbound-empty flag pin |

## Verification
The bench fills the inbound register under eight configurations, mixing bus styles, strobe levels, byte-select senses, widths and flag options. A design that steered bytes by the wrong pin level would assemble swapped words, and one that completed on the low byte would raise the full flag early. Directed cases pair a host write with a core read, and a core write with the end of a host read, in the same cycle. A wrong priority there would leave a stale flag. Further cases check that status reads leave the empty flag alone and that an added status inversion shows up. The last case flips the strobe polarity while the strobe pin sits at the newly active level; without the resynchronising cycle this would record a phantom host write.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int CFG_W = 7;

  typedef struct packed {
    logic st_inv;   // status empty-bit inversion
    logic merge;    // merge flags onto full pin
    logic fpol;     // flag pin inversion
    logic bsense;   // byte-select level picking low byte
    logic dpol;     // data strobe active level
    logic proto;    // 1: direction line + data strobe
    logic wide;     // 1: 16-bit host transfers
  } hp_cfg_t;
endpackage

// File: rtl/hp_ctl_reg.sv
module hp_ctl_reg
  import hp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [CFG_W-1:0] wdata,
  output hp_cfg_t         cfg,
  output logic            resync,
  output logic [DW-1:0]   rdata
);
  localparam int PAD_W = DW - CFG_W;

  hp_cfg_t cfg_q, cfg_d;
  logic    rs_q;

  always_comb begin
    cfg_d = cfg_q;
    if (wr) cfg_d = hp_cfg_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      rs_q  <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      rs_q  <= wr;
    end
  end

  assign cfg    = cfg_q;
  assign resync = rs_q;
  assign rdata  = {{PAD_W{1'b0}}, cfg_q};

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cfg_q));
endmodule

// File: rtl/hp_strobe_dec.sv
module hp_strobe_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic proto,
  input  logic dpol,
  input  logic resync,
  input  logic line_a,
  input  logic line_b,
  output logic wr_evt,
  output logic rd_end
);
  logic ds_act, rd_act, wr_act;
  logic rd_q, wr_q;

  always_comb begin
    ds_act = (line_b == dpol);
    if (proto) begin
      rd_act = ds_act & line_a;
      wr_act = ds_act & ~line_a;
    end else begin
      rd_act = ~line_b;
      wr_act = ~line_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
    end
  end

  assign wr_evt = wr_act & ~wr_q & ~resync;
  assign rd_end = ~rd_act & rd_q & ~resync;

  p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);
  p_rd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end |=> !rd_end);
endmodule

// File: rtl/hp_flags.sv
module hp_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_full,
  input  logic clr_full,
  input  logic set_empty,
  input  logic clr_empty,
  output logic full,
  output logic empty
);
  logic full_q, full_d, empty_q, empty_d;

  always_comb begin
    full_d = full_q;
    if (set_full)      full_d = 1'b1;
    else if (clr_full) full_d = 1'b0;
    empty_d = empty_q;
    if (clr_empty)      empty_d = 1'b0;
    else if (set_empty) empty_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      full_q  <= full_d;
      empty_q <= empty_d;
    end
  end

  assign full  = full_q;
  assign empty = empty_q;

  p_full_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_full |=> full);
  p_full_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_full && !set_full) |=> !full);
  p_empty_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_empty |=> !empty);
  p_empty_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_empty && !clr_empty) |=> empty);
endmodule

// File: rtl/par_host_port.sv
module par_host_port
  import hp_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_rd,
  output logic [DW-1:0] core_rdata,
  input  logic          core_wr,
  input  logic [DW-1:0] core_wdata,
  input  logic          ctl_wr,
  input  logic [DW-1:0] ctl_wdata,
  output logic [DW-1:0] ctl_rdata,
  input  logic          h_line_a,
  input  logic          h_line_b,
  input  logic          h_bsel,
  input  logic          h_stat,
  input  logic [DW-1:0] h_din,
  output logic [DW-1:0] h_dout,
  output logic          flag_full,
  output logic          flag_empty
);
  localparam int HI_W = DW - BW;

  logic [1:0]    rst_sync;
  logic          rst_ni;
  hp_cfg_t       cfg;
  logic          resync, wr_evt, rd_end, lo_sel;
  logic          done_wr, done_rd, full, empty;
  logic [DW-1:0] in_q, in_d, out_q, out_d, status;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  hp_ctl_reg #(.DW(DW)) u_ctl (
    .clk(clk), .rst_n(rst_ni), .wr(ctl_wr), .wdata(ctl_wdata[CFG_W-1:0]),
    .cfg(cfg), .resync(resync), .rdata(ctl_rdata)
  );

  hp_strobe_dec u_strb (
    .clk(clk), .rst_n(rst_ni), .proto(cfg.proto), .dpol(cfg.dpol),
    .resync(resync), .line_a(h_line_a), .line_b(h_line_b),
    .wr_evt(wr_evt), .rd_end(rd_end)
  );

  assign lo_sel  = (h_bsel == cfg.bsense);
  assign done_wr = wr_evt & (cfg.wide | ~lo_sel);
  assign done_rd = rd_end & ~h_stat & (cfg.wide | ~lo_sel);

  hp_flags u_flags (
    .clk(clk), .rst_n(rst_ni),
    .set_full(done_wr), .clr_full(core_rd),
    .set_empty(done_rd), .clr_empty(core_wr),
    .full(full), .empty(empty)
  );

  always_comb begin
    in_d = in_q;
    if (wr_evt) begin
      if (cfg.wide)   in_d = h_din;
      else if (lo_sel) in_d = {in_q[DW-1:BW], h_din[BW-1:0]};
      else            in_d = {h_din[HI_W-1:0], in_q[BW-1:0]};
    end
    out_d = out_q;
    if (core_wr) out_d = core_wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      out_q <= '0;
    end else begin
      in_q  <= in_d;
      out_q <= out_d;
    end
  end

  always_comb begin
    status = '0;
    status[0] = full;
    status[1] = empty ^ cfg.st_inv;
    if (h_stat)       h_dout = status;
    else if (cfg.wide) h_dout = out_q;
    else if (lo_sel)  h_dout = {{HI_W{1'b0}}, out_q[BW-1:0]};
    else              h_dout = {{BW{1'b0}}, out_q[DW-1:BW]};
  end

  assign core_rdata = in_q;
  assign flag_full  = (full | (cfg.merge & empty)) ^ cfg.fpol;
  assign flag_empty = empty ^ cfg.fpol;

  p_lowbyte_nodone_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_evt && !cfg.wide && lo_sel && !full && !core_rd) |=> !full);
  p_stat_keeps_empty_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_end && h_stat && !empty && !core_wr) |=> !empty);
endmodule

// File: tb/par_host_port_test.sv
module par_host_port_test;
  logic        clk = 1'b0;
  logic        rst_n, core_rd, core_wr, ctl_wr;
  logic [15:0] core_rdata, core_wdata, ctl_wdata, ctl_rdata, h_din, h_dout;
  logic        h_line_a, h_line_b, h_bsel, h_stat, flag_full, flag_empty;
  logic [6:0]  cur;
  logic [15:0] rd;
  int          checks = 0, fails = 0;

  // {cfg[6:0], data[15:0]}
  localparam logic [22:0] VEC [8] = '{
    {7'b0000001, 16'hA55A}, {7'b0000000, 16'h1234},
    {7'b0001000, 16'hBEEF}, {7'b0000011, 16'hC3C3},
    {7'b0000111, 16'h0F1E}, {7'b0010110, 16'h5678},
    {7'b0110001, 16'h9ABC}, {7'b0101010, 16'h7E81}
  };

  always #4 clk = ~clk;

  par_host_port uut (
    .clk(clk), .rst_n(rst_n), .core_rd(core_rd), .core_rdata(core_rdata),
    .core_wr(core_wr), .core_wdata(core_wdata), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .h_line_a(h_line_a),
    .h_line_b(h_line_b), .h_bsel(h_bsel), .h_stat(h_stat), .h_din(h_din),
    .h_dout(h_dout), .flag_full(flag_full), .flag_empty(flag_empty)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_idle();
    if (cur[1]) begin h_line_a = 1'b0; h_line_b = ~cur[2]; end
    else begin h_line_a = 1'b1; h_line_b = 1'b1; end
  endtask

  task automatic wr_ctl(input logic [15:0] v, input bit idle);
    ctl_wdata = v; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0; cur = v[6:0];
    if (idle) set_idle();
    @(negedge clk);
  endtask

  task automatic core_write(input logic [15:0] d);
    core_wdata = d; core_wr = 1'b1;
    @(negedge clk);
    core_wr = 1'b0;
  endtask

  task automatic core_read();
    core_rd = 1'b1;
    @(negedge clk);
    core_rd = 1'b0;
  endtask

  task automatic host_write(input logic [15:0] d, input bit hi);
    h_din = d;
    h_bsel = hi ? ~cur[3] : cur[3];
    if (cur[1]) begin h_line_a = 1'b0; h_line_b = cur[2]; end
    else h_line_a = 1'b0;
    @(negedge clk);
    set_idle();
    @(negedge clk);
  endtask

  task automatic host_read(input bit hi, input bit st, output logic [15:0] d);
    h_stat = st;
    h_bsel = hi ? ~cur[3] : cur[3];
    if (cur[1]) begin h_line_a = 1'b1; h_line_b = cur[2]; end
    else h_line_b = 1'b0;
    @(negedge clk);
    d = h_dout;
    if (cur[1]) h_line_b = ~cur[2];
    else h_line_b = 1'b1;
    @(negedge clk);
    h_stat = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; core_rd = 0; core_wr = 0; ctl_wr = 0;
    core_wdata = '0; ctl_wdata = '0; h_din = '0; h_bsel = 0; h_stat = 0;
    h_line_a = 1; h_line_b = 1; cur = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ctl", ctl_rdata, 16'h0000);
    chk("R1 inreg", core_rdata, 16'h0000);
    chk("R1 full", {15'b0, flag_full}, 16'h0000);
    chk("R1 empty", {15'b0, flag_empty}, 16'h0001);

    // vector table: host fills inbound register under many configs
    for (int i = 0; i < 8; i++) begin
      logic [6:0]  c;
      logic [15:0] d;
      logic        pre;
      string       tag;
      c = VEC[i][22:16]; d = VEC[i][15:0];
      tag = {c[1] ? "R4" : "R3", c[0] ? " R5" : " R6"};
      wr_ctl({9'b0, c}, 1'b1);
      pre = c[5] ^ c[4];                 // full 0, empty 1 here
      chk({tag, " R11 pre"}, {15'b0, flag_full}, {15'b0, pre});
      chk("R10 empty pin", {15'b0, flag_empty}, {15'b0, ~c[4]});
      if (c[0]) host_write(d, 1'b0);
      else begin
        host_write({8'h00, d[7:0]}, 1'b0);
        chk("R6 low byte no done", {15'b0, flag_full}, {15'b0, pre});
        host_write({8'h00, d[15:8]}, 1'b1);
      end
      chk({tag, " data"}, core_rdata, d);
      chk("R7 R10 full set", {15'b0, flag_full}, {15'b0, ~c[4]});
      core_read();
      chk("R7 full clr", {15'b0, flag_full}, {15'b0, pre});
    end

    // R2 reserved bits
    wr_ctl(16'h0000, 1'b1);
    wr_ctl(16'hFFFF, 1'b1);
    chk("R2 readback", ctl_rdata, 16'h007F);
    wr_ctl(16'h0000, 1'b1);

    // 8-bit read path
    core_write(16'hCAFE);
    chk("R8 empty clr", {15'b0, flag_empty}, 16'h0000);
    host_read(1'b0, 1'b0, rd);
    chk("R6 rd low", rd, 16'h00FE);
    chk("R6 low rd no done", {15'b0, flag_empty}, 16'h0000);
    host_read(1'b1, 1'b0, rd);
    chk("R6 rd high", rd, 16'h00CA);
    chk("R8 empty set", {15'b0, flag_empty}, 16'h0001);

    // status reads
    core_write(16'h1357);
    host_read(1'b0, 1'b1, rd);
    chk("R9 status", rd, 16'h0000);
    chk("R9 no done", {15'b0, flag_empty}, 16'h0000);
    wr_ctl(16'h0040, 1'b1);
    host_read(1'b0, 1'b1, rd);
    chk("R9 status inv", rd, 16'h0002);
    wr_ctl(16'h0041, 1'b1);
    host_read(1'b0, 1'b0, rd);
    chk("R5 rd word", rd, 16'h1357);
    chk("R8 empty set16", {15'b0, flag_empty}, 16'h0001);

    // collision: host write and core read together
    wr_ctl(16'h0001, 1'b1);
    h_din = 16'h4444; h_line_a = 1'b0; core_rd = 1'b1;
    @(negedge clk);
    h_line_a = 1'b1; core_rd = 1'b0;
    @(negedge clk);
    chk("R7 set wins", {15'b0, flag_full}, 16'h0001);
    chk("R5 data", core_rdata, 16'h4444);
    core_read();
    chk("R7 clr", {15'b0, flag_full}, 16'h0000);

    // collision: end of host read and core write together
    core_write(16'h2222);
    h_line_b = 1'b0;
    @(negedge clk);
    h_line_b = 1'b1; core_wdata = 16'h3333; core_wr = 1'b1;
    @(negedge clk);
    core_wr = 1'b0;
    chk("R8 clr wins", {15'b0, flag_empty}, 16'h0000);
    host_read(1'b0, 1'b0, rd);
    chk("R5 new word", rd, 16'h3333);

    // config change must not start a transfer
    wr_ctl(16'h0003, 1'b1);           // idle: a=0, b=1
    wr_ctl(16'h0007, 1'b0);           // b=1 now active level
    @(negedge clk);
    chk("R12 no phantom", {15'b0, flag_full}, 16'h0000);
    chk("R12 data kept", core_rdata, 16'h4444);
    h_line_b = 1'b0;
    @(negedge clk);
    chk("R12 after idle", {15'b0, flag_full}, 16'h0000);

    // reset mid-run
    wr_ctl(16'h003F, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 ctl rst", ctl_rdata, 16'h0000);
    chk("R1 full rst", {15'b0, flag_full}, 16'h0000);
    chk("R1 empty rst", {15'b0, flag_empty}, 16'h0001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule